// File: doc/BRIEF.md
# E1 Backplane Frame Pulse Generator

This block drives one alignment-marker wire that travels beside a 2.048 Mbit/s E1 PCM stream on a backplane. It keeps a bit position inside the 256-bit frame, split as 32 timeslots of 8 bits, and two frame positions inside 16-frame multiframes: one for signaling and one for CRC. Both multiframe counters run freely modulo 16, so their markers keep coming every 16th frame even if no alignment has ever been found.

A 3-bit mode input selects the marker waveform. The choices are a one-clock pulse per frame, a one-clock pulse per signaling multiframe, a one-clock pulse per CRC multiframe, a composite level that carries both multiframe alignments on one wire, and a level that is high over the two overhead timeslots. Three strobes realign the counters. The frame strobe restarts the bit count at once. Each multiframe strobe arms a reload of its own frame count, and the reload takes effect at the next frame boundary. All state, including the output register, changes on the falling edge of the clock. The clock is either the backplane clock or the recovered line clock, and the choice is made outside the block.

Top module: `e1_fpulse_gen`

## Requirements
- R1: While `rst_ni` is low at a falling clock edge, the bit position goes to bit 1 of the frame, both frame positions go to frame 1, and `marker_o` goes low. After release, the first frame marker appears 256 clocks after the last reset edge.
- R2: With mode code 0 (frame), `marker_o` is high for exactly one clock, during bit 1 of every frame, so rising edges are 256 clocks apart.
- R3: With mode code 1 (signaling multiframe), `marker_o` is high for one clock, during bit 1 of the frame whose signaling position is frame 1.
- R4: With mode code 2 (CRC multiframe), `marker_o` is high for one clock, during bit 1 of the frame whose CRC position is frame 1.
- R5: With no strobes, the bit count wraps every 256 clocks and each frame count wraps every 16 frames, so multiframe markers repeat every 4096 clocks. Frame counts change only at a frame boundary.
- R6: With mode code 3 (composite), `marker_o` goes high at bit 1 of signaling frame 1 and stays high through bit 1 of CRC frame 1, then goes low. If the CRC start lies k frames after the signaling start, the high time is k*256+1 clocks.
- R7: With mode code 3, when both multiframe starts fall on the same bit, `marker_o` is a single one-clock pulse.
- R8: With mode code 4 (overhead), `marker_o` is high for all 8 bits of timeslot 0 and of timeslot 16, where timeslot = bit index div 8. That is bit indices 0-7 and 128-135 of each frame; the output is low elsewhere.
- R9: Mode codes 5, 6 and 7 hold `marker_o` low.
- R10: A high `frm_sync_i` at a falling edge makes the bit loaded at that edge bit 1 of a new frame. That edge also counts as a frame boundary for both frame counts.
- R11: A high `sig_sync_i` reloads the signaling frame count to frame 1 at the next frame boundary, or at the same edge if that edge is a boundary. The CRC count is not touched.
- R12: A high `crc_sync_i` reloads the CRC frame count to frame 1 in the same way as R11. The signaling count is not touched.
- R13: Inputs are sampled and `marker_o` changes only on the falling edge of `clk_i`. The output is stable across the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Selected backplane or recovered line clock; all state moves on its falling edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| mode_i | input | 3 | Marker waveform select (0 frame, 1 signaling MF, 2 CRC MF, 3 composite, 4 overhead) |
| frm_sync_i | input | 1 | Frame alignment strobe; restarts the bit count |
| sig_sync_i | input | 1 | Signaling multiframe alignment strobe |
| crc_sync_i | input | 1 | CRC multiframe alignment strobe |
| marker_o | output | 1 | Registered alignment marker |

## Verification
The bench builds the block with its default parameters: 8-bit timeslots, 32 timeslots per frame, overhead slots 0 and 16, and 16-frame multiframes. With these values a full 4096-clock multiframe period can be run several times within the cycle budget. That makes it possible to measure multiframe pulse spacing, composite high times spanning two frames, and the realignment done by each strobe against the real frame length. A smaller geometry would hide mistakes in the wrap of the sub-bit and slot counts at their true terminal values.

// File: rtl/e1fp_pkg.sv
`timescale 1ns/1ps
package e1fp_pkg;

   localparam int unsigned FP_MODE_W = 3;

   typedef enum logic [FP_MODE_W-1:0] {
      FP_MODE_FRAME = 3'd0,
      FP_MODE_SIGMF = 3'd1,
      FP_MODE_CRCMF = 3'd2,
      FP_MODE_COMBO = 3'd3,
      FP_MODE_OHEAD = 3'd4
   } fp_mode_e;

   localparam int unsigned FP_MF_CNT = 2;
   localparam int unsigned FP_MF_SIG = 0;
   localparam int unsigned FP_MF_CRC = 1;

endpackage

// File: rtl/e1fp_bit_ctr.sv
`timescale 1ns/1ps
module e1fp_bit_ctr #(
   parameter int unsigned TS_BITS      = 8,
   parameter int unsigned TS_PER_FRAME = 32,
   parameter int unsigned SB_W         = 3,
   parameter int unsigned TS_W         = 5
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            sync_i,
   output logic [SB_W-1:0] sbit_q_o,
   output logic [TS_W-1:0] slot_q_o,
   output logic [TS_W-1:0] slot_d_o,
   output logic            frame_edge_o
);

   localparam logic [SB_W-1:0] SB_LAST = SB_W'(TS_BITS - 1);
   localparam logic [TS_W-1:0] TS_LAST = TS_W'(TS_PER_FRAME - 1);

   logic [SB_W-1:0] sbit_q, sbit_d;
   logic [TS_W-1:0] slot_q, slot_d;
   logic            at_last_bit, at_last_slot;

   always_comb begin
      at_last_bit  = (sbit_q == SB_LAST);
      at_last_slot = (slot_q == TS_LAST);
      frame_edge_o = sync_i | (at_last_bit & at_last_slot);
      sbit_d       = sbit_q;
      slot_d       = slot_q;
      if (sync_i) begin
         sbit_d = '0;
         slot_d = '0;
      end else if (at_last_bit) begin
         sbit_d = '0;
         slot_d = at_last_slot ? '0 : slot_q + 1'b1;
      end else begin
         sbit_d = sbit_q + 1'b1;
      end
   end

   always_ff @(negedge clk_i) begin
      if (!rst_ni) begin
         sbit_q <= '0;
         slot_q <= '0;
      end else begin
         sbit_q <= sbit_d;
         slot_q <= slot_d;
      end
   end

   assign sbit_q_o = sbit_q;
   assign slot_q_o = slot_q;
   assign slot_d_o = slot_d;

endmodule

// File: rtl/e1fp_mf_ctr.sv
`timescale 1ns/1ps
module e1fp_mf_ctr #(
   parameter int unsigned MF_FRAMES = 16,
   parameter int unsigned FR_W      = 4
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            frame_edge_i,
   input  logic            resync_i,
   output logic [FR_W-1:0] fr_q_o,
   output logic            mf_start_o
);

   localparam logic [FR_W-1:0] FR_LAST = FR_W'(MF_FRAMES - 1);

   logic [FR_W-1:0] fr_q, fr_d;
   logic            pend_q, pend_d, pend_eff;

   always_comb begin
      pend_eff = pend_q | resync_i;
      fr_d     = fr_q;
      pend_d   = pend_eff;
      if (frame_edge_i) begin
         pend_d = 1'b0;
         if (pend_eff)
            fr_d = '0;
         else
            fr_d = (fr_q == FR_LAST) ? '0 : fr_q + 1'b1;
      end
      mf_start_o = frame_edge_i & (fr_d == '0);
   end

   always_ff @(negedge clk_i) begin
      if (!rst_ni) begin
         fr_q   <= '0;
         pend_q <= 1'b0;
      end else begin
         fr_q   <= fr_d;
         pend_q <= pend_d;
      end
   end

   assign fr_q_o = fr_q;

endmodule

// File: rtl/e1fp_wave.sv
`timescale 1ns/1ps
module e1fp_wave
   import e1fp_pkg::*;
#(
   parameter int unsigned TS_W        = 5,
   parameter int unsigned OHEAD_TS_LO = 0,
   parameter int unsigned OHEAD_TS_HI = 16
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [FP_MODE_W-1:0] mode_i,
   input  logic                 frame_start_i,
   input  logic                 sig_start_i,
   input  logic                 crc_start_i,
   input  logic [TS_W-1:0]      slot_d_i,
   output logic                 marker_o
);

   localparam int unsigned N_OH = 2;

   logic [N_OH-1:0] oh_hit;
   logic            combo, hold_q, hold_d, mark_d, mark_q;

   for (genvar g = 0; g < N_OH; g++) begin : g_oh
      localparam int unsigned SLOT = (g == 0) ? OHEAD_TS_LO : OHEAD_TS_HI;
      assign oh_hit[g] = (slot_d_i == TS_W'(SLOT));
   end

   always_comb begin
      combo  = sig_start_i | hold_q;
      hold_d = combo & ~crc_start_i;
      case (fp_mode_e'(mode_i))
         FP_MODE_FRAME: mark_d = frame_start_i;
         FP_MODE_SIGMF: mark_d = sig_start_i;
         FP_MODE_CRCMF: mark_d = crc_start_i;
         FP_MODE_COMBO: mark_d = combo;
         FP_MODE_OHEAD: mark_d = |oh_hit;
         default:       mark_d = 1'b0;
      endcase
   end

   always_ff @(negedge clk_i) begin
      if (!rst_ni) begin
         hold_q <= 1'b0;
         mark_q <= 1'b0;
      end else begin
         hold_q <= hold_d;
         mark_q <= mark_d;
      end
   end

   assign marker_o = mark_q;

endmodule

// File: rtl/e1_fpulse_gen.sv
`timescale 1ns/1ps
module e1_fpulse_gen
   import e1fp_pkg::*;
#(
   parameter int unsigned TS_BITS      = 8,
   parameter int unsigned TS_PER_FRAME = 32,
   parameter int unsigned MF_FRAMES    = 16,
   parameter int unsigned OHEAD_TS_LO  = 0,
   parameter int unsigned OHEAD_TS_HI  = 16
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [FP_MODE_W-1:0] mode_i,
   input  logic                 frm_sync_i,
   input  logic                 sig_sync_i,
   input  logic                 crc_sync_i,
   output logic                 marker_o
);

   localparam int unsigned SB_W = (TS_BITS > 1) ? $clog2(TS_BITS) : 1;
   localparam int unsigned TS_W = $clog2(TS_PER_FRAME);
   localparam int unsigned FR_W = $clog2(MF_FRAMES);

   if (TS_PER_FRAME < 2) begin : g_bad_slots
      $error("TS_PER_FRAME must be at least 2");
   end
   if (MF_FRAMES < 2) begin : g_bad_mf
      $error("MF_FRAMES must be at least 2");
   end
   if (OHEAD_TS_LO >= TS_PER_FRAME || OHEAD_TS_HI >= TS_PER_FRAME) begin : g_bad_oh
      $error("overhead timeslots must lie inside the frame");
   end
   if (OHEAD_TS_LO == OHEAD_TS_HI) begin : g_dup_oh
      $error("overhead timeslots must differ");
   end

   logic [SB_W-1:0]       bit_sub;
   logic [TS_W-1:0]       bit_slot, slot_nxt;
   logic                  frame_edge;
   logic [FP_MF_CNT-1:0]  mf_resync, mf_start;
   logic [FR_W-1:0]       mf_fr [FP_MF_CNT];
   logic [FR_W-1:0]       sig_fr, crc_fr;

   e1fp_bit_ctr #(
      .TS_BITS      (TS_BITS),
      .TS_PER_FRAME (TS_PER_FRAME),
      .SB_W         (SB_W),
      .TS_W         (TS_W)
   ) u_bit (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .sync_i       (frm_sync_i),
      .sbit_q_o     (bit_sub),
      .slot_q_o     (bit_slot),
      .slot_d_o     (slot_nxt),
      .frame_edge_o (frame_edge)
   );

   assign mf_resync[FP_MF_SIG] = sig_sync_i;
   assign mf_resync[FP_MF_CRC] = crc_sync_i;

   for (genvar k = 0; k < FP_MF_CNT; k++) begin : g_mf
      e1fp_mf_ctr #(
         .MF_FRAMES (MF_FRAMES),
         .FR_W      (FR_W)
      ) u_mf (
         .clk_i        (clk_i),
         .rst_ni       (rst_ni),
         .frame_edge_i (frame_edge),
         .resync_i     (mf_resync[k]),
         .fr_q_o       (mf_fr[k]),
         .mf_start_o   (mf_start[k])
      );
   end

   assign sig_fr = mf_fr[FP_MF_SIG];
   assign crc_fr = mf_fr[FP_MF_CRC];

   e1fp_wave #(
      .TS_W        (TS_W),
      .OHEAD_TS_LO (OHEAD_TS_LO),
      .OHEAD_TS_HI (OHEAD_TS_HI)
   ) u_wave (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .mode_i        (mode_i),
      .frame_start_i (frame_edge),
      .sig_start_i   (mf_start[FP_MF_SIG]),
      .crc_start_i   (mf_start[FP_MF_CRC]),
      .slot_d_i      (slot_nxt),
      .marker_o      (marker_o)
   );

endmodule

// File: rtl/e1fp_checker.sv
`timescale 1ns/1ps
module e1fp_checker #(
   parameter int unsigned SB_W        = 3,
   parameter int unsigned TS_W        = 5,
   parameter int unsigned FR_W        = 4,
   parameter int unsigned OHEAD_TS_LO = 0,
   parameter int unsigned OHEAD_TS_HI = 16
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic [2:0]      mode_i,
   input logic            frm_sync_i,
   input logic            marker_o,
   input logic [SB_W-1:0] bit_sub,
   input logic [TS_W-1:0] bit_slot,
   input logic [FR_W-1:0] sig_fr,
   input logic [FR_W-1:0] crc_fr
);

   logic armed_q = 1'b0;
   always_ff @(negedge clk_i) armed_q <= 1'b1;

   logic at_bit1;
   assign at_bit1 = (bit_slot == '0) && (bit_sub == '0);

   // R1: reset leaves bit 1 of frame 1 with the marker low
   a_r1_reset_state: assert property (@(negedge clk_i)
      (armed_q && !$past(rst_ni)) |->
      (!marker_o && at_bit1 && sig_fr == '0 && crc_fr == '0));

   // R2: frame marker only at bit 1
   a_r2_frame_at_bit1: assert property (@(negedge clk_i) disable iff (!rst_ni)
      ($past(mode_i) == 3'd0 && marker_o) |-> at_bit1);

   // R2: every bit 1 after reset carries the frame marker
   a_r2_frame_present: assert property (@(negedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(mode_i) == 3'd0 && at_bit1) |-> marker_o);

   // R5: frame positions move only at a frame start
   a_r5_frames_hold: assert property (@(negedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !at_bit1) |-> ($stable(sig_fr) && $stable(crc_fr)));

   // R6: composite is high at the signaling multiframe start
   a_r6_combo_rise: assert property (@(negedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(mode_i) == 3'd3 && at_bit1 && sig_fr == '0) |-> marker_o);

   // R8: overhead level follows the two overhead slots
   a_r8_ohead_slots: assert property (@(negedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(mode_i) == 3'd4) |->
      (marker_o == (bit_slot == TS_W'(OHEAD_TS_LO) || bit_slot == TS_W'(OHEAD_TS_HI))));

   // R9: unused codes keep the marker low
   a_r9_idle_codes: assert property (@(negedge clk_i) disable iff (!rst_ni)
      ($past(mode_i) > 3'd4) |-> !marker_o);

   // R10: a frame strobe lands on bit 1
   a_r10_frame_sync: assert property (@(negedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(frm_sync_i)) |-> at_bit1);

endmodule

bind e1_fpulse_gen e1fp_checker #(
   .SB_W        (SB_W),
   .TS_W        (TS_W),
   .FR_W        (FR_W),
   .OHEAD_TS_LO (OHEAD_TS_LO),
   .OHEAD_TS_HI (OHEAD_TS_HI)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .mode_i     (mode_i),
   .frm_sync_i (frm_sync_i),
   .marker_o   (marker_o),
   .bit_sub    (bit_sub),
   .bit_slot   (bit_slot),
   .sig_fr     (sig_fr),
   .crc_fr     (crc_fr)
);

// File: tb/e1_fpulse_gen_tb_top.sv
`timescale 1ns/1ps
module e1_fpulse_gen_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode = 3'd0;
   logic       fsync = 1'b0, ssync = 1'b0, csync = 1'b0;
   logic       mark;

   always #2.5 clk = ~clk;

   e1_fpulse_gen dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .mode_i     (mode),
      .frm_sync_i (fsync),
      .sig_sync_i (ssync),
      .crc_sync_i (csync),
      .marker_o   (mark)
   );

   typedef struct {
      logic  exp;
      string tag;
   } exp_t;

   exp_t q[$];
   int total = 0, bad = 0, cyc = 0;
   int rise_cyc = 0, last_gap = 0, last_width = 0, hi_cnt = 0;
   logic prev_out = 1'b0;

   // reference state built from the requirements
   int mb = 0, ms = 0, mc = 0;
   bit mps = 0, mpc = 0, mh = 0;

   // driver side: expected marker for the bit loaded at this falling edge
   always @(negedge clk) begin
      exp_t it;
      bit   bnd, ss, cs, cmb;
      if (!rst_n) begin
         mb = 0; ms = 0; mc = 0; mps = 0; mpc = 0; mh = 0;
         it.exp = 1'b0; it.tag = "R1";
      end else begin
         bnd = fsync || (mb == 255);
         mps = mps || ssync;
         mpc = mpc || csync;
         if (bnd) begin
            ms = mps ? 0 : (ms + 1) % 16;
            mc = mpc ? 0 : (mc + 1) % 16;
            mps = 0; mpc = 0; mb = 0;
         end else begin
            mb = mb + 1;
         end
         ss  = (mb == 0) && (ms == 0);
         cs  = (mb == 0) && (mc == 0);
         cmb = ss || mh;
         mh  = cmb && !cs;
         case (mode)
            3'd0: begin it.exp = (mb == 0); it.tag = "R2"; end
            3'd1: begin it.exp = ss;        it.tag = "R3"; end
            3'd2: begin it.exp = cs;        it.tag = "R4"; end
            3'd3: begin it.exp = cmb;       it.tag = "R6"; end
            3'd4: begin it.exp = (mb < 8) || (mb >= 128 && mb < 136); it.tag = "R8"; end
            default: begin it.exp = 1'b0;   it.tag = "R9"; end
         endcase
      end
      q.push_back(it);
   end

   // monitor side: pop and compare at the rising edge
   always @(posedge clk) begin
      exp_t it;
      logic o;
      o = mark;
      cyc++;
      if (q.size() > 0) begin
         it = q.pop_front();
         total++;
         if (o !== it.exp) begin
            bad++;
            $display("FAIL %s cyc=%0d actual=%b expected=%b", it.tag, cyc, o, it.exp);
         end
      end
      if (o && !prev_out) begin last_gap = cyc - rise_cyc; rise_cyc = cyc; end
      if (!o && prev_out) last_width = cyc - rise_cyc;
      if (o) hi_cnt++;
      prev_out = o;
   end

   // R13: no change across the rising edge
   always @(posedge clk) begin
      logic v;
      v = mark;
      #2.0;
      total++;
      if (mark !== v) begin
         bad++;
         $display("FAIL R13 actual=%b expected=%b", mark, v);
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic pulse(input bit f, input bit s, input bit c);
      fsync = f; ssync = s; csync = c;
      tick();
      fsync = 1'b0; ssync = 1'b0; csync = 1'b0;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int c0;
      step(4);
      chk("R1", int'(mark), 0);
      rst_n = 1'b1;
      c0 = cyc;
      step(600);
      chk("R1", rise_cyc - c0, 512);
      chk("R2", last_gap, 256);
      chk("R2", last_width, 1);

      // R10: frame strobe restarts the frame at once
      pulse(1, 0, 0);
      chk("R10", int'(mark), 1);
      step(300);
      chk("R10", last_gap, 256);

      // R3 / R5: free-running signaling multiframe
      mode = 3'd1;
      step(8200);
      chk("R5", last_gap, 4096);
      chk("R3", last_width, 1);

      // R11: signaling strobe takes effect at the next boundary
      pulse(1, 0, 0);
      c0 = cyc;
      step(100);
      pulse(0, 1, 0);
      step(300);
      chk("R11", rise_cyc - c0, 256);
      step(4096);
      chk("R11", last_gap, 4096);

      // R4 / R12: CRC multiframe and its strobe
      mode = 3'd2;
      pulse(1, 0, 0);
      c0 = cyc;
      step(100);
      pulse(0, 0, 1);
      step(300);
      chk("R12", rise_cyc - c0, 256);
      step(4096);
      chk("R4", last_gap, 4096);
      chk("R4", last_width, 1);

      // R6: composite, CRC start two frames after signaling start
      mode = 3'd3;
      pulse(1, 0, 0);
      step(50);
      pulse(0, 1, 0);
      step(512);
      pulse(0, 0, 1);
      step(4400);
      chk("R6", last_width, 513);

      // R7: coincident starts give one clock
      pulse(1, 0, 0);
      step(20);
      pulse(0, 1, 1);
      step(300 + 8192);
      chk("R7", last_width, 1);
      chk("R7", last_gap, 4096);

      // R8: overhead slots
      mode = 3'd4;
      step(600);
      chk("R8", last_width, 8);
      chk("R8", last_gap, 128);

      // R9: unused codes
      for (int m = 5; m < 8; m++) begin
         mode = 3'(m);
         hi_cnt = 0;
         step(300);
         chk("R9", hi_cnt, 0);
      end

      // R1: reset in the middle of a run
      mode = 3'd0;
      step(100);
      rst_n = 1'b0;
      step(3);
      chk("R1", int'(mark), 0);
      rst_n = 1'b1;
      c0 = cyc;
      step(300);
      chk("R1", rise_cyc - c0, 256);

      step(4);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule